// File: doc/BRIEF.md
# Second-Operand Shift Stage

This block prepares the second operand of an arithmetic or logic unit. It takes a data word and moves it by a selected kind of shift: logical left, logical right, arithmetic right, rotate right, or a one-place rotate right through the carry flag. It also produces the carry-out that the flag logic needs. The shift amount comes from one of two sources. A 5-bit immediate field has its own legal ranges for each kind. The other source is the low byte of a register.

The shift itself is combinational. The shifted word and its carry are captured in output registers, so a result appears one clock after its inputs. A typical use is an add whose second operand is shifted first. For example, 5 shifted left by one gives 0xA, and adding that to 5 gives 0xF.

Top module: `operand_shifter`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `result_o` and `carry_o` are 0.
- R2: The inputs sampled at a rising edge set the outputs from that edge onward. The outputs do not change between edges.
- R3: Kind code 0 is logical left. An immediate amount n of 1–31 gives x<<n with carry x[32-n]. An amount of 0 passes x unchanged with carry = `carry_i`. For example, 0x80000004 shifted by 1 gives 0x00000008 with carry 1.
- R4: Kind code 1 is logical right (zero fill) and kind code 2 is arithmetic right (bit 31 replicated). For both, an immediate n of 1–31 shifts by n with carry x[n-1]. An immediate field of 0 means 32: logical right then gives 0, and arithmetic right gives all copies of bit 31. In both cases the carry is x[31].
- R5: Kind code 3 is rotate right. An immediate n of 1–31 gives (x>>n)|(x<<(32-n)), and the carry is the new bit 31. An immediate of 0 passes x unchanged with carry = `carry_i`.
- R6: Kind code 4 rotates right by one through the carry. The result is {`carry_i`, x[31:1]} and the carry is x[0]. Both amount inputs are ignored.
- R7: When `amt_sel_reg_i` is 1, the amount is `amt_reg_i` (8 bits). A value of 0 passes x unchanged with carry = `carry_i` for kinds 0–3.
- R8: Register amount with logical shifts. An amount of 32 gives 0, with carry x[0] for a left shift and x[31] for a right shift. Any amount above 32 gives 0 with carry 0.
- R9: Register amount with arithmetic right. Any amount of 32 or more gives 32 copies of x[31], and the carry is x[31].
- R10: Register amount with rotate right. The rotation is the amount modulo 32. A nonzero multiple of 32 leaves x unchanged with carry x[31].
- R11: The amount source that `amt_sel_reg_i` does not select has no effect on the outputs.
- R12: Kind codes 5–7 pass x unchanged with carry = `carry_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | 32 | Word to be shifted |
| kind_i | input | 3 | Shift kind code (0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry) |
| amt_imm_i | input | 5 | Immediate shift amount field |
| amt_reg_i | input | 8 | Register-sourced shift amount (low byte) |
| amt_sel_reg_i | input | 1 | 1 selects the register amount, 0 the immediate |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Registered shifted operand |
| carry_o | output | 1 | Registered shifter carry-out |

## Verification
Two things can land in the same cycle. One is the amount decode, where an immediate field of 0 means 32 for the right shifts, and a register amount of 0 or above 32 means pass-through or saturation. The other is the carry selection, where the incoming flag either passes through or is replaced by a data bit. The bench provokes both at once with directed words whose bits 0 and 31 differ from `carry_i`, driven at amounts 0, 1, 31, 32, 33 and 255. It then adds random vectors over all kinds and both sources. A behavioural bit-loop model predicts the word and the carry for every vector, and the registered outputs are compared against it one edge later.

// File: rtl/opshift_pkg.sv
package opshift_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned AMT_W  = 8;
  localparam int unsigned IMM_W  = $clog2(DATA_W);

  localparam logic [2:0] KIND_LSL = 3'd0;
  localparam logic [2:0] KIND_LSR = 3'd1;
  localparam logic [2:0] KIND_ASR = 3'd2;
  localparam logic [2:0] KIND_ROR = 3'd3;
  localparam logic [2:0] KIND_RRX = 3'd4;
endpackage

// File: rtl/opshift_amount.sv
module opshift_amount
  import opshift_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned AW = AMT_W,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [2:0]    kind,
  input  logic [IW-1:0] imm,
  input  logic [AW-1:0] regamt,
  input  logic          sel_reg,
  output logic [AW-1:0] amt
);
  logic right_kind;
  assign right_kind = (kind == KIND_LSR) || (kind == KIND_ASR);

  always_comb begin
    if (sel_reg) begin
      amt = regamt;
    end else if (right_kind && (imm == '0)) begin
      amt = AW'(W);
    end else begin
      amt = AW'(imm);
    end
  end
endmodule

// File: rtl/opshift_core.sv
module opshift_core
  import opshift_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned AW = AMT_W
) (
  input  logic [W-1:0]  x,
  input  logic [2:0]    kind,
  input  logic [AW-1:0] amt,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout
);
  localparam int unsigned SW = $clog2(W);
  localparam int unsigned CW = SW + 2;

  logic [CW-1:0]        amt_cl;
  logic [CW-1:0]        amt_as;
  logic [W:0]           lsl_t;
  logic [W:0]           lsr_t;
  logic signed [W:0]    asr_t;
  logic [2*W-1:0]       ror_t;
  logic [W-1:0]         ror_res;

  assign amt_cl  = (amt > AW'(W)) ? CW'(W + 1) : CW'(amt);
  assign amt_as  = (amt_cl > CW'(W)) ? CW'(W) : amt_cl;
  assign lsl_t   = {1'b0, x} << amt_cl;
  assign lsr_t   = {x, 1'b0} >> amt_cl;
  assign asr_t   = $signed({x, 1'b0}) >>> amt_as;
  assign ror_t   = {x, x} >> amt[SW-1:0];
  assign ror_res = ror_t[W-1:0];

  always_comb begin
    res  = x;
    cout = cin;
    if (kind == KIND_RRX) begin
      res  = {cin, x[W-1:1]};
      cout = x[0];
    end else if (amt != '0) begin
      case (kind)
        KIND_LSL: begin res = lsl_t[W-1:0]; cout = lsl_t[W]; end
        KIND_LSR: begin res = lsr_t[W:1];   cout = lsr_t[0]; end
        KIND_ASR: begin res = asr_t[W:1];   cout = asr_t[0]; end
        KIND_ROR: begin res = ror_res;      cout = ror_res[W-1]; end
        default:  begin res = x;            cout = cin; end
      endcase
    end
  end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import opshift_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned AW = AMT_W,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  data_i,
  input  logic [2:0]    kind_i,
  input  logic [IW-1:0] amt_imm_i,
  input  logic [AW-1:0] amt_reg_i,
  input  logic          amt_sel_reg_i,
  input  logic          carry_i,
  output logic [W-1:0]  result_o,
  output logic          carry_o
);
  logic [AW-1:0] eff_amt;
  logic [W-1:0]  sh_res;
  logic          sh_c;

  opshift_amount #(.W(W), .AW(AW), .IW(IW)) u_amount (
    .kind    (kind_i),
    .imm     (amt_imm_i),
    .regamt  (amt_reg_i),
    .sel_reg (amt_sel_reg_i),
    .amt     (eff_amt)
  );

  opshift_core #(.W(W), .AW(AW)) u_core (
    .x    (data_i),
    .kind (kind_i),
    .amt  (eff_amt),
    .cin  (carry_i),
    .res  (sh_res),
    .cout (sh_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
    end else begin
      result_o <= sh_res;
      carry_o  <= sh_c;
    end
  end

  // R6: rotate through carry
  a_r6_rrx: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && kind_i == KIND_RRX) |->
      (result_o == {$past(carry_i), $past(data_i[W-1:1])}) && (carry_o == $past(data_i[0])));

  // R7: register amount of zero passes through
  a_r7_reg_zero: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && amt_sel_reg_i && amt_reg_i == '0 && kind_i < KIND_RRX) |->
      (result_o == $past(data_i)) && (carry_o == $past(carry_i)));

  // R8: logical shifts beyond the width clear everything
  a_r8_over_clear: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && amt_sel_reg_i && amt_reg_i > AW'(W) && (kind_i == KIND_LSL || kind_i == KIND_LSR)) |->
      (result_o == '0) && !carry_o);

  // R9: arithmetic right saturates to sign
  a_r9_asr_sign: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && amt_sel_reg_i && amt_reg_i >= AW'(W) && kind_i == KIND_ASR) |->
      (result_o == {W{$past(data_i[W-1])}}) && (carry_o == $past(data_i[W-1])));

  // R4: immediate field zero on logical right means full-width shift
  a_r4_lsr_imm32: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !amt_sel_reg_i && amt_imm_i == '0 && kind_i == KIND_LSR) |->
      (result_o == '0) && (carry_o == $past(data_i[W-1])));

  // R3: immediate left shift of zero keeps the flag
  a_r3_lsl_imm0: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !amt_sel_reg_i && amt_imm_i == '0 && kind_i == KIND_LSL) |->
      (result_o == $past(data_i)) && (carry_o == $past(carry_i)));

  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (result_o == '0) && !carry_o);
endmodule

// File: tb/operand_shifter_bench.sv
module operand_shifter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] data_i = '0;
  logic [2:0]  kind_i = '0;
  logic [4:0]  amt_imm_i = '0;
  logic [7:0]  amt_reg_i = '0;
  logic        amt_sel_reg_i = 1'b0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  operand_shifter u_operand_shifter (
    .clk(clk), .rst(rst), .data_i(data_i), .kind_i(kind_i),
    .amt_imm_i(amt_imm_i), .amt_reg_i(amt_reg_i),
    .amt_sel_reg_i(amt_sel_reg_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o)
  );

  function automatic logic [32:0] model(input logic [2:0] k, input logic [31:0] x,
                                        input logic [4:0] imm, input logic [7:0] ra,
                                        input logic ur, input logic ci);
    int n;
    logic [31:0] r;
    logic c;
    r = x; c = ci;
    if (ur) n = ra;
    else if ((k == 3'd1 || k == 3'd2) && imm == 0) n = 32;
    else n = imm;
    if (k == 3'd4) begin
      r = {ci, x[31:1]}; c = x[0];
    end else if (k <= 3'd3 && n != 0) begin
      case (k)
        3'd0: begin
          for (int i = 0; i < 32; i++) r[i] = (i - n >= 0) ? x[i-n] : 1'b0;
          c = (n <= 32) ? x[32-n] : 1'b0;
        end
        3'd1: begin
          for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? x[i+n] : 1'b0;
          c = (n <= 32) ? x[n-1] : 1'b0;
        end
        3'd2: begin
          for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? x[i+n] : x[31];
          c = (n <= 32) ? x[n-1] : x[31];
        end
        default: begin
          int m;
          m = n % 32;
          if (m == 0) begin r = x; c = x[31]; end
          else begin
            for (int i = 0; i < 32; i++) r[i] = x[(i+m)%32];
            c = x[m-1];
          end
        end
      endcase
    end
    return {c, r};
  endfunction

  task automatic compare_head();
    logic [32:0] e;
    string t;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if ({carry_o, result_o} !== e) begin
      errors++;
      $display("FAIL %s: actual res=%h c=%b expected res=%h c=%b", t, result_o, carry_o, e[31:0], e[32]);
    end
  endtask

  task automatic step(input logic [2:0] k, input logic [31:0] x, input logic [4:0] imm,
                      input logic [7:0] ra, input logic ur, input logic ci, input string t);
    logic [32:0] held;
    @(negedge clk);
    compare_head();
    held = {carry_o, result_o};
    kind_i = k; data_i = x; amt_imm_i = imm; amt_reg_i = ra; amt_sel_reg_i = ur; carry_i = ci;
    exp_q.push_back(model(k, x, imm, ra, ur, ci));
    tag_q.push_back(t);
    #1;
    checks++;
    if ({carry_o, result_o} !== held) begin
      errors++;
      $display("FAIL R2: output moved before edge actual=%h expected=%h", {carry_o, result_o}, held);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (result_o !== 32'h0 || carry_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual res=%h c=%b expected res=0 c=0", result_o, carry_o);
    end
    rst = 1'b0;
    // R3 left shifts
    step(3'd0, 32'h8000_0004, 5'd1, 8'd0, 1'b0, 1'b0, "R3 lsl1");
    step(3'd0, 32'h0000_0005, 5'd1, 8'd0, 1'b0, 1'b0, "R3 five<<1");
    step(3'd0, 32'h1234_5678, 5'd0, 8'd9, 1'b0, 1'b1, "R3 lsl0 R11");
    step(3'd0, 32'h0000_0003, 5'd31, 8'd0, 1'b0, 1'b0, "R3 lsl31");
    // R4 right shifts from immediate
    step(3'd1, 32'h8000_0001, 5'd1, 8'd0, 1'b0, 1'b0, "R4 lsr1");
    step(3'd1, 32'h8000_0000, 5'd0, 8'd0, 1'b0, 1'b0, "R4 lsr32");
    step(3'd2, 32'h8000_0010, 5'd4, 8'd0, 1'b0, 1'b0, "R4 asr4");
    step(3'd2, 32'h8000_0000, 5'd0, 8'd0, 1'b0, 1'b0, "R4 asr32");
    step(3'd2, 32'h7fff_fffe, 5'd0, 8'd0, 1'b0, 1'b1, "R4 asr32 pos");
    // R5 rotate
    step(3'd3, 32'h0000_0001, 5'd1, 8'd0, 1'b0, 1'b0, "R5 ror1");
    step(3'd3, 32'hF000_000F, 5'd0, 8'd0, 1'b0, 1'b1, "R5 ror0");
    step(3'd3, 32'h1234_5678, 5'd31, 8'd0, 1'b0, 1'b0, "R5 ror31");
    // R6 through carry, amounts ignored
    step(3'd4, 32'h0000_0001, 5'd7, 8'd40, 1'b1, 1'b1, "R6 rrx");
    step(3'd4, 32'hFFFF_FFFE, 5'd0, 8'd0, 1'b0, 1'b0, "R6 rrx b");
    // R7 register zero
    step(3'd1, 32'h8000_0001, 5'd5, 8'd0, 1'b1, 1'b1, "R7 reg0 R11");
    step(3'd2, 32'h8000_0001, 5'd5, 8'd0, 1'b1, 1'b0, "R7 reg0 asr");
    // R8 register logical limits
    step(3'd0, 32'h0000_0001, 5'd0, 8'd32, 1'b1, 1'b0, "R8 lsl32");
    step(3'd1, 32'h8000_0000, 5'd0, 8'd32, 1'b1, 1'b0, "R8 lsr32");
    step(3'd0, 32'hFFFF_FFFF, 5'd1, 8'd33, 1'b1, 1'b1, "R8 lsl33");
    step(3'd1, 32'hFFFF_FFFF, 5'd1, 8'd255, 1'b1, 1'b1, "R8 lsr255");
    // R9 register arithmetic limits
    step(3'd2, 32'h8000_0000, 5'd1, 8'd32, 1'b1, 1'b0, "R9 asr32");
    step(3'd2, 32'h4000_0000, 5'd1, 8'd200, 1'b1, 1'b1, "R9 asr200");
    // R10 register rotate
    step(3'd3, 32'h8000_0001, 5'd1, 8'd64, 1'b1, 1'b0, "R10 ror64");
    step(3'd3, 32'h0000_00F0, 5'd1, 8'd36, 1'b1, 1'b0, "R10 ror36");
    // R12 reserved kinds
    step(3'd5, 32'hDEAD_BEEF, 5'd3, 8'd3, 1'b0, 1'b1, "R12 k5");
    step(3'd7, 32'hCAFE_F00D, 5'd3, 8'd3, 1'b1, 1'b0, "R12 k7");
    // mixed random sweep, R11 across both sources
    for (int i = 0; i < 400; i++) begin
      step(3'($urandom_range(0, 5)), $urandom(), 5'($urandom()), 8'($urandom_range(0, 70)),
           1'($urandom()), 1'($urandom()), "R11 random");
    end
    @(negedge clk);
    compare_head();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule